// File: doc/BRIEF.md
# Serial Page Bootstrap Loader

This block fills one 256-byte page of RAM from a serial line before the processor runs. It sits between a receive-only UART input and the system memory bus. It holds the processor in reset with the bus granted to itself and writes each received byte to the next location in the page. As soon as the last byte of the page is written, it hands the bus and the processor back together.

Two straps are sampled while system reset is high. The first, `boot_serial`, picks between two modes. In serial bootstrap mode the loader runs as described above. In RAM bootstrap mode the loader stays idle and the processor leaves reset at once, so it boots from RAM contents that were already in place.

The second strap, `cpu_high_vec`, picks the target page. It is set to 1 for processors that fetch their start vectors from the top of the address space, and to 0 for processors that start executing at address zero.

Top module: `serial_boot_loader`

## Requirements
- R1: While `rst` is high, and afterwards until the last byte of the page is written in serial bootstrap mode, `cpu_hold_reset` reads 1, `mem_we` reads 0, and `dma_has_bus` reads the `boot_serial` value that was sampled during reset.
- R2: If `boot_serial` is 0 during reset, `dma_has_bus` stays 0. `cpu_hold_reset` falls to 0 after the first rising clock edge at which `rst` is low. Received bytes then cause no write.
- R3: The receiver accepts 8N1 frames with the line idling high: one low start bit, eight data bits with the least significant bit first, and one high stop bit. One bit lasts 16 × `OVS_DIV` clock cycles. Each bit is sampled near its middle.
- R4: A frame whose stop bit reads low is discarded. It causes no write and does not advance the page index.
- R5: Each accepted byte produces a write strobe `mem_we` that lasts exactly one clock cycle, with the received byte on `mem_wdata`. Byte k of the page (counting from 0) goes to address base + k.
- R6: The base address is 0x0000 when `cpu_high_vec` was 0 during reset, and 0xFF00 when it was 1.
- R7: In the cycle after the 256th write, `dma_has_bus` and `cpu_hold_reset` both fall to 0. They stay 0 until the next reset. Bytes received after that point cause no write.
- R8: Changes on `boot_serial` and `cpu_high_vec` while `rst` is low have no effect on ownership or addresses.
- R9: The write for a frame has finished before that frame's stop bit ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; the straps are sampled while it is high |
| boot_serial | input | 1 | Mode strap: 1 selects serial bootstrap mode, 0 selects RAM bootstrap mode |
| cpu_high_vec | input | 1 | Page strap: 1 selects the top page, 0 selects the bottom page |
| uart_rx | input | 1 | Serial receive line, idles high |
| mem_addr | output | 16 | Memory address driven by the loader |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write strobe, one clock cycle per byte |
| dma_has_bus | output | 1 | High while the loader owns the memory bus |
| cpu_hold_reset | output | 1 | High while the processor is held in reset |

## Verification
A page index that skips or repeats shows at the ports on the very next write strobe, as an address that breaks the base + k sequence. Because of this, the bench compares every strobe's address and data against a queue of the bytes it sent. A wrong ownership phase shows within one clock cycle of the 256th strobe, as an early, late or split release of `dma_has_bus` and `cpu_hold_reset`. A phase that starts in the wrong state shows in the first cycle after reset. A receiver that loses bit alignment shows after a single frame, as wrong data on the write, or as a missing write before the frame's stop bit ends.

// File: rtl/sboot_pkg.sv
package sboot_pkg;
  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP,
    RX_WAITHI
  } rx_state_t;

  typedef enum logic {
    PH_LOAD,
    PH_RUN
  } phase_t;
endpackage

// File: rtl/sboot_uart_rx.sv
module sboot_uart_rx #(
  parameter int OVS_DIV = 2,
  parameter int OVS     = 16,
  parameter int DW      = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx,
  output logic          vld,
  output logic [DW-1:0] data
);
  import sboot_pkg::*;

  localparam int CW = $clog2(OVS);
  localparam int BW = $clog2(DW);

  logic tick;

  // Oversampling tick: every clock when no division is needed.
  generate
    if (OVS_DIV == 1) begin : g_nodiv
      assign tick = 1'b1;
    end else begin : g_div
      localparam int DVW = $clog2(OVS_DIV);
      logic [DVW-1:0] dcnt;
      always_ff @(posedge clk) begin
        if (rst) dcnt <= '0;
        else if (dcnt == DVW'(OVS_DIV - 1)) dcnt <= '0;
        else dcnt <= dcnt + 1'b1;
      end
      assign tick = (dcnt == DVW'(OVS_DIV - 1));
    end
  endgenerate

  logic [1:0]    sync;
  logic          rxs;
  rx_state_t     st;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bitn;
  logic [DW-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sync <= 2'b11;
    else sync <= {sync[0], rx};
  end
  assign rxs = sync[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= RX_IDLE;
      cnt  <= '0;
      bitn <= '0;
      sh   <= '0;
      vld  <= 1'b0;
      data <= '0;
    end else begin
      vld <= 1'b0;
      if (st == RX_WAITHI) begin
        if (rxs) st <= RX_IDLE;
      end else if (tick) begin
        case (st)
          RX_IDLE: begin
            if (!rxs) begin
              st  <= RX_START;
              cnt <= '0;
            end
          end
          RX_START: begin
            cnt <= cnt + 1'b1;
            if (cnt == CW'(OVS / 2 - 1)) begin
              cnt  <= '0;
              bitn <= '0;
              st   <= rxs ? RX_IDLE : RX_DATA;
            end
          end
          RX_DATA: begin
            cnt <= cnt + 1'b1;
            if (cnt == CW'(OVS - 1)) begin
              cnt <= '0;
              sh  <= {rxs, sh[DW-1:1]};
              if (bitn == BW'(DW - 1)) st <= RX_STOP;
              else bitn <= bitn + 1'b1;
            end
          end
          RX_STOP: begin
            cnt <= cnt + 1'b1;
            if (cnt == CW'(OVS - 1)) begin
              cnt <= '0;
              if (rxs) begin
                vld  <= 1'b1;
                data <= sh;
                st   <= RX_IDLE;
              end else begin
                st <= RX_WAITHI;
              end
            end
          end
          default: st <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/sboot_page_writer.sv
module sboot_page_writer #(
  parameter int AW         = 16,
  parameter int DW         = 8,
  parameter int PAGE_BYTES = 256
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          high_sel,
  input  logic          enable,
  input  logic          in_vld,
  input  logic [DW-1:0] in_data,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] wdata,
  output logic          we,
  output logic          last
);
  localparam int            CNTW      = $clog2(PAGE_BYTES);
  localparam logic [AW-1:0] HIGH_BASE = {AW{1'b1}} - AW'(PAGE_BYTES - 1);

  logic            hi_q;
  logic [CNTW-1:0] cnt;
  logic [AW-1:0]   base;

  always_comb base = hi_q ? HIGH_BASE : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q  <= high_sel;
      cnt   <= '0;
      addr  <= '0;
      wdata <= '0;
      we    <= 1'b0;
      last  <= 1'b0;
    end else begin
      we   <= 1'b0;
      last <= 1'b0;
      if (enable && in_vld) begin
        addr  <= base + AW'(cnt);
        wdata <= in_data;
        we    <= 1'b1;
        last  <= (cnt == CNTW'(PAGE_BYTES - 1));
        cnt   <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sboot_handoff.sv
module sboot_handoff (
  input  logic clk,
  input  logic rst,
  input  logic serial_mode,
  input  logic last_write,
  output logic dma_own,
  output logic cpu_hold
);
  import sboot_pkg::*;

  phase_t ph;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph       <= serial_mode ? PH_LOAD : PH_RUN;
      dma_own  <= serial_mode;
      cpu_hold <= 1'b1;
    end else begin
      case (ph)
        PH_LOAD: begin
          if (last_write) begin
            ph       <= PH_RUN;
            dma_own  <= 1'b0;
            cpu_hold <= 1'b0;
          end
        end
        default: begin
          dma_own  <= 1'b0;
          cpu_hold <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/serial_boot_loader.sv
module serial_boot_loader #(
  parameter int AW         = 16,
  parameter int DW         = 8,
  parameter int PAGE_BYTES = 256,
  parameter int OVS        = 16,
  parameter int OVS_DIV    = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          boot_serial,
  input  logic          cpu_high_vec,
  input  logic          uart_rx,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  output logic          dma_has_bus,
  output logic          cpu_hold_reset
);
  logic          rx_vld;
  logic [DW-1:0] rx_data;
  logic          last_wr;

  sboot_uart_rx #(
    .OVS_DIV(OVS_DIV),
    .OVS    (OVS),
    .DW     (DW)
  ) u_rx (
    .clk (clk),
    .rst (rst),
    .rx  (uart_rx),
    .vld (rx_vld),
    .data(rx_data)
  );

  sboot_page_writer #(
    .AW        (AW),
    .DW        (DW),
    .PAGE_BYTES(PAGE_BYTES)
  ) u_wr (
    .clk     (clk),
    .rst     (rst),
    .high_sel(cpu_high_vec),
    .enable  (dma_has_bus),
    .in_vld  (rx_vld),
    .in_data (rx_data),
    .addr    (mem_addr),
    .wdata   (mem_wdata),
    .we      (mem_we),
    .last    (last_wr)
  );

  sboot_handoff u_ho (
    .clk        (clk),
    .rst        (rst),
    .serial_mode(boot_serial),
    .last_write (last_wr),
    .dma_own    (dma_has_bus),
    .cpu_hold   (cpu_hold_reset)
  );
endmodule

// File: rtl/sboot_chk.sv
module sboot_chk #(
  parameter int AW         = 16,
  parameter int PAGE_BYTES = 256
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] mem_addr,
  input logic          mem_we,
  input logic          dma_has_bus,
  input logic          cpu_hold_reset
);
  localparam int PB = $clog2(PAGE_BYTES);

  AST_WE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we); // R5

  AST_WE_ONLY_WITH_BUS: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> dma_has_bus); // R7

  AST_BUS_IMPLIES_HOLD: assert property (@(posedge clk) disable iff (rst)
    dma_has_bus |-> cpu_hold_reset); // R1

  AST_ADDR_IN_PAGE: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_addr[AW-1:PB] == '0 || mem_addr[AW-1:PB] == '1)); // R6

  AST_NO_REGRAB: assert property (@(posedge clk) disable iff (rst)
    !dma_has_bus |=> !dma_has_bus); // R2

  AST_RELEASE_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
    ($fell(dma_has_bus) && !$past(rst)) |-> $past(mem_we)); // R7

  AST_HOLD_RELEASE_JOINT: assert property (@(posedge clk) disable iff (rst)
    ($fell(cpu_hold_reset) && !$past(rst)) |-> !dma_has_bus); // R7
endmodule

bind serial_boot_loader sboot_chk #(
  .AW        (AW),
  .PAGE_BYTES(PAGE_BYTES)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .mem_addr      (mem_addr),
  .mem_we        (mem_we),
  .dma_has_bus   (dma_has_bus),
  .cpu_hold_reset(cpu_hold_reset)
);

// File: tb/sim_serial_boot_loader.sv
module sim_serial_boot_loader;
  localparam int CLK_PERIOD = 10;
  localparam int OVS_DIV_TB = 1;
  localparam int BIT_CLKS   = 16 * OVS_DIV_TB;
  localparam int PAGE       = 256;
  localparam int WD_CYCLES  = 190000;

  logic        clk;
  logic        rst;
  logic        boot_serial;
  logic        cpu_high_vec;
  logic        uart_rx;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_we;
  logic        dma_has_bus;
  logic        cpu_hold_reset;

  serial_boot_loader #(.OVS_DIV(OVS_DIV_TB)) u0 (
    .clk           (clk),
    .rst           (rst),
    .boot_serial   (boot_serial),
    .cpu_high_vec  (cpu_high_vec),
    .uart_rx       (uart_rx),
    .mem_addr      (mem_addr),
    .mem_wdata     (mem_wdata),
    .mem_we        (mem_we),
    .dma_has_bus   (dma_has_bus),
    .cpu_hold_reset(cpu_hold_reset)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  bit         started, r_rst, r_mode, r_hi, mode_lat;
  bit         exp_dma, exp_hold, rel_next, prev_we;
  int         n, base;
  logic [7:0] q[$];
  logic [7:0] ram[int];
  logic [7:0] exp_b;
  string      tag;

  always @(posedge clk) begin
    r_rst   = rst;
    r_mode  = boot_serial;
    r_hi    = cpu_high_vec;
    started = 1'b1;
  end

  always @(negedge clk) begin
    if (started && !done) begin
      if (r_rst) begin
        exp_dma  = r_mode;
        exp_hold = 1'b1;
        mode_lat = r_mode;
        n        = 0;
        base     = r_hi ? (65536 - PAGE) : 0;
        rel_next = 1'b0;
        ram.delete();
      end else if (rel_next) begin
        exp_dma  = 1'b0;
        exp_hold = 1'b0;
        rel_next = 1'b0;
      end else if (!exp_dma) begin
        exp_hold = 1'b0;
      end
      tag = r_rst ? "R1 reset" : (!mode_lat ? "R2 ram mode" : (n >= PAGE ? "R7 released" : "R1 loading"));
      chk(dma_has_bus == exp_dma, {tag, " dma_has_bus"}, int'(dma_has_bus), int'(exp_dma));
      chk(cpu_hold_reset == exp_hold, {tag, " cpu_hold_reset"}, int'(cpu_hold_reset), int'(exp_hold));
      if (mem_we) begin
        chk(!prev_we, "R5 strobe longer than one clock", 1, 0);
        if (!exp_dma || r_rst) begin
          chk(1'b0, "R7 write without bus", int'(mem_addr), -1);
        end else if (q.size() == 0) begin
          chk(1'b0, "R4 write with no accepted frame", int'(mem_wdata), -1);
        end else begin
          exp_b = q.pop_front();
          chk(mem_addr == 16'(base + n), "R6 write address", int'(mem_addr), base + n);
          chk(mem_wdata == exp_b, "R5 write data", int'(mem_wdata), int'(exp_b));
          ram[int'(mem_addr)] = mem_wdata;
          n++;
          if (n == PAGE) rel_next = 1'b1;
        end
      end
      prev_we = mem_we;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic hold_bits(input int k);
    repeat (k * BIT_CLKS) @(posedge clk);
    #1;
  endtask

  // R3: 8N1, LSB first, idle high
  task automatic send_byte(input logic [7:0] b, input bit good_stop, input bit expect_wr);
    if (expect_wr) q.push_back(b);
    uart_rx = 1'b0;
    hold_bits(1);
    for (int i = 0; i < 8; i++) begin
      uart_rx = b[i];
      hold_bits(1);
    end
    uart_rx = good_stop;
    hold_bits(1);
    uart_rx = 1'b1;
    if (!good_stop) hold_bits(1);
  endtask

  task automatic do_reset(input bit mode, input bit hi);
    @(posedge clk); #1;
    rst          = 1'b1;
    boot_serial  = mode;
    cpu_high_vec = hi;
    q.delete();
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
  endtask

  function automatic logic [7:0] pat1(input int i);
    return 8'((i * 37 + 11) ^ (i >> 3));
  endfunction

  function automatic logic [7:0] pat2(input int i);
    return 8'((255 - i) ^ 8'h5A);
  endfunction

  task automatic finish_run();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired after %0d cycles", WD_CYCLES);
    finish_run();
  end

  // ---------------- main sequence ----------------
  initial begin
    rst          = 1'b1;
    boot_serial  = 1'b1;
    cpu_high_vec = 1'b0;
    uart_rx      = 1'b1;
    repeat (3) @(posedge clk);

    // R1: state while reset is high
    @(negedge clk);
    chk(dma_has_bus == 1'b1, "R1 reset dma_has_bus", int'(dma_has_bus), 1);
    chk(cpu_hold_reset == 1'b1, "R1 reset cpu_hold_reset", int'(cpu_hold_reset), 1);
    chk(mem_we == 1'b0, "R1 reset mem_we", int'(mem_we), 0);
    @(posedge clk); #1;
    rst = 1'b0;
    repeat (4) @(posedge clk);
    #1;
    chk(cpu_hold_reset == 1'b1, "R1 hold before any byte", int'(cpu_hold_reset), 1);

    // Load 1: bottom page, one bad frame, straps toggled mid-load
    for (int i = 0; i < PAGE; i++) begin
      if (i == 10) begin
        send_byte(8'hA5, 1'b0, 1'b0);
        chk(n == 10, "R4 bad stop bit advanced index", n, 10);
      end
      if (i == 100) begin
        boot_serial  = 1'b0;
        cpu_high_vec = 1'b1;
      end
      send_byte(pat1(i), 1'b1, 1'b1);
      chk(n == i + 1, "R9 write done by end of stop bit", n, i + 1);
    end
    chk(dma_has_bus == 1'b0, "R7 bus released after page", int'(dma_has_bus), 0);
    chk(cpu_hold_reset == 1'b0, "R7 cpu released after page", int'(cpu_hold_reset), 0);
    for (int a = 0; a < PAGE; a++) begin
      chk(ram.exists(a) && ram[a] == pat1(a), "R5 low page content",
          ram.exists(a) ? int'(ram[a]) : -1, int'(pat1(a)));
    end
    chk(ram.exists(10) && ram[10] == pat1(10), "R4 byte after bad frame",
        ram.exists(10) ? int'(ram[10]) : -1, int'(pat1(10)));
    chk(ram.exists(101) && ram[101] == pat1(101), "R8 strap change mid-load",
        ram.exists(101) ? int'(ram[101]) : -1, int'(pat1(101)));
    send_byte(8'h3C, 1'b1, 1'b0);
    send_byte(8'hC3, 1'b1, 1'b0);
    chk(n == PAGE, "R7 bytes after handoff written", n, PAGE);

    // Load 2: top page
    do_reset(1'b1, 1'b1);
    for (int i = 0; i < PAGE; i++) begin
      send_byte(pat2(i), 1'b1, 1'b1);
    end
    chk(n == PAGE, "R6 top page write count", n, PAGE);
    for (int a = 0; a < PAGE; a++) begin
      chk(ram.exists(65280 + a) && ram[65280 + a] == pat2(a), "R6 top page content",
          ram.exists(65280 + a) ? int'(ram[65280 + a]) : -1, int'(pat2(a)));
    end
    chk(dma_has_bus == 1'b0, "R7 top page release", int'(dma_has_bus), 0);

    // Load 3: RAM bootstrap mode
    do_reset(1'b0, 1'b0);
    @(negedge clk);
    chk(cpu_hold_reset == 1'b1, "R2 hold before first edge", int'(cpu_hold_reset), 1);
    @(negedge clk);
    chk(cpu_hold_reset == 1'b0, "R2 hold released", int'(cpu_hold_reset), 0);
    chk(dma_has_bus == 1'b0, "R2 no bus in ram mode", int'(dma_has_bus), 0);
    @(posedge clk); #1;
    send_byte(8'h77, 1'b1, 1'b0);
    chk(n == 0, "R2 byte in ram mode written", n, 0);
    boot_serial = 1'b1;
    repeat (8) @(posedge clk);
    #1;
    chk(dma_has_bus == 1'b0, "R8 strap change after reset", int'(dma_has_bus), 0);
    chk(cpu_hold_reset == 1'b0, "R8 hold after strap change", int'(cpu_hold_reset), 0);

    repeat (4) @(posedge clk);
    finish_run();
  end
endmodule